// File: doc/BRIEF.md
# Correlating Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps a short global record of the most recent resolved branch outcomes. That record chooses one of several per-address tables of two-bit saturating counters. With the default parameters, a two-bit history picks one of four tables of 1024 counters each. The total counter count is the same as a single 4096-entry table, but the counters are spread by recent control flow.

A fetch stage presents its PC on the lookup port and gets back a direction in the same cycle. With the direction it gets the history value that made the choice. That history travels down the pipe with the branch. When the branch resolves, the execute stage presents the PC, that saved history and the real outcome on the update port. The update trains the counter in the table the saved history names, and it shifts the outcome into the live history.

Top module: `gbp_corr_predictor`

## Requirements
- R1: After reset the history reads 00, every counter holds 01 (weakly not taken), and every lookup predicts not taken.
- R2: `pred_taken_o` is combinational from `lookup_pc_i` and the current history. It equals the MSB of the addressed counter (1 = taken).
- R3: On each cycle with `upd_valid_i` high, the history shifts at the clock edge. Bit 1 takes `upd_taken_i` (newest outcome) and bit 0 takes the old bit 1 (older outcome). `pred_hist_o` always shows the current history.
- R4: History value 00 (neither of the last two taken) selects table 0. Value 01 (only the older taken) selects table 1. Value 10 (only the newer taken) selects table 2. Value 11 (both taken) selects table 3. Lookups use the live history. Updates use `upd_hist_i`.
- R5: A taken update increments the addressed counter and saturates at 11.
- R6: A not-taken update decrements the addressed counter and saturates at 00.
- R7: An update changes only the counter at its own table and index. Every other counter in every table keeps its value.
- R8: The counter index is PC bits [11:2]. PC bits [1:0] and the bits above 11 do not affect which counter is used.
- R9: With `upd_valid_i` low, neither the history nor any counter changes, whatever the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lookup_pc_i | input | 32 | Fetch PC to predict |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |
| pred_hist_o | output | 2 | History value used for this prediction |
| upd_valid_i | input | 1 | Resolved branch update strobe |
| upd_pc_i | input | 32 | PC of the resolved branch |
| upd_hist_i | input | 2 | History snapshot saved at prediction time |
| upd_taken_i | input | 1 | Resolved outcome, 1 = taken |

## Verification
A lookup result is due in the cycle its PC is applied, since no register sits on the read path. The bench therefore samples one time step after changing `lookup_pc_i`, away from any edge. An update is driven at the falling edge and takes effect at the next rising edge. Both the new history and the trained counter are read back from the falling edge after that. Counter contents are exposed only through the prediction bit. The bench steers the live history to the wanted table using updates to a scratch index, then infers counter values from sequences of direction flips.

// File: rtl/gbp_pkg.sv
package gbp_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_INIT = 2'b01;
  localparam ctr_t CTR_MAX  = 2'b11;
  localparam ctr_t CTR_MIN  = 2'b00;

  function automatic ctr_t ctr_next(ctr_t cur, logic taken);
    if (taken) return (cur == CTR_MAX) ? CTR_MAX : cur + 2'd1;
    else       return (cur == CTR_MIN) ? CTR_MIN : cur - 2'd1;
  endfunction
endpackage

// File: rtl/gbp_index.sv
module gbp_index #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 10
) (
  input  logic [PC_W-1:0]  pc_i,
  output logic [IDX_W-1:0] idx_o
);
  // word-aligned PC: drop byte offset, keep IDX_W bits above it
  assign idx_o = pc_i[IDX_W+1:2];

  logic unused_pc_bits;
  assign unused_pc_bits = ^{pc_i[PC_W-1:IDX_W+2], pc_i[1:0]};
endmodule

// File: rtl/gbp_history.sv
module gbp_history #(
  parameter int HIST_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [HIST_W-1:0] hist_o
);
  logic [HIST_W-1:0] hist_q;

  // newest outcome enters at the MSB
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hist_q <= '0;
    else if (shift_i) hist_q <= {bit_i, hist_q[HIST_W-1:1]};
  end

  assign hist_o = hist_q;

  a_r3_newest_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> hist_q[HIST_W-1] == $past(bit_i));
  a_r3_older_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> hist_q[HIST_W-2] == $past(hist_q[HIST_W-1]));
  a_r9_hist_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(hist_q));
endmodule

// File: rtl/gbp_table.sv
module gbp_table
  import gbp_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_taken_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_taken_i
);
  localparam int DEPTH = 1 << IDX_W;

  ctr_t ctr_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) ctr_q[i] <= CTR_INIT;
    end else if (wr_en_i) begin
      ctr_q[wr_idx_i] <= ctr_next(ctr_q[wr_idx_i], wr_taken_i);
    end
  end

  assign rd_taken_o = ctr_q[rd_idx_i][1];

  a_r5_count_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_taken_i && ctr_q[wr_idx_i] != CTR_MAX
    |=> ctr_q[$past(wr_idx_i)] == $past(ctr_q[wr_idx_i]) + 2'd1);
  a_r5_ceiling: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_taken_i && ctr_q[wr_idx_i] == CTR_MAX
    |=> ctr_q[$past(wr_idx_i)] == CTR_MAX);
  a_r6_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !wr_taken_i && ctr_q[wr_idx_i] == CTR_MIN
    |=> ctr_q[$past(wr_idx_i)] == CTR_MIN);
  a_r9_entry_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ctr_q[$past(rd_idx_i)] == $past(ctr_q[rd_idx_i]));
endmodule

// File: rtl/gbp_corr_predictor.sv
module gbp_corr_predictor #(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 10,
  parameter int HIST_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PC_W-1:0]   lookup_pc_i,
  output logic              pred_taken_o,
  output logic [HIST_W-1:0] pred_hist_o,
  input  logic              upd_valid_i,
  input  logic [PC_W-1:0]   upd_pc_i,
  input  logic [HIST_W-1:0] upd_hist_i,
  input  logic              upd_taken_i
);
  localparam int N_TBL = 1 << HIST_W;

  logic [HIST_W-1:0] hist;
  logic [IDX_W-1:0]  rd_idx, wr_idx;
  logic [N_TBL-1:0]  tbl_taken, tbl_we;

  gbp_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_rd_index (
    .pc_i(lookup_pc_i), .idx_o(rd_idx));
  gbp_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_wr_index (
    .pc_i(upd_pc_i), .idx_o(wr_idx));

  gbp_history #(.HIST_W(HIST_W)) u_history (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (upd_valid_i),
    .bit_i   (upd_taken_i),
    .hist_o  (hist)
  );

  for (genvar t = 0; t < N_TBL; t++) begin : g_tbl
    // history value t (newest outcome in MSB) owns table t
    assign tbl_we[t] = upd_valid_i && (upd_hist_i == HIST_W'(t));

    gbp_table #(.IDX_W(IDX_W)) u_table (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .rd_idx_i   (rd_idx),
      .rd_taken_o (tbl_taken[t]),
      .wr_en_i    (tbl_we[t]),
      .wr_idx_i   (wr_idx),
      .wr_taken_i (upd_taken_i)
    );
  end

  assign pred_taken_o = tbl_taken[hist];
  assign pred_hist_o  = hist;

  a_r7_single_table: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tbl_we));
  a_r9_idle_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |-> tbl_we == '0);
  a_r3_hist_port: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i |=> pred_hist_o[HIST_W-1] == $past(upd_taken_i));
endmodule

// File: tb/gbp_corr_predictor_bench.sv
module gbp_corr_predictor_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] lookup_pc = '0;
  logic        pred_taken;
  logic [1:0]  pred_hist;
  logic        upd_valid = 0;
  logic [31:0] upd_pc = '0;
  logic [1:0]  upd_hist = '0;
  logic        upd_taken = 0;

  int n_chk = 0;
  int n_fail = 0;

  // reference state derived from the requirements
  int         m_ctr [4][1024];
  logic [1:0] m_hist;

  localparam int SCRATCH = 1023;

  always #5 clk = ~clk;

  gbp_corr_predictor u_gbp_corr_predictor (
    .clk_i(clk), .rst_ni(rst_n),
    .lookup_pc_i(lookup_pc), .pred_taken_o(pred_taken), .pred_hist_o(pred_hist),
    .upd_valid_i(upd_valid), .upd_pc_i(upd_pc), .upd_hist_i(upd_hist),
    .upd_taken_i(upd_taken)
  );

  function automatic logic [31:0] pc_of(int idx);
    return {20'h0, idx[9:0], 2'b00};
  endfunction

  task automatic check(logic act, logic exp, string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic check_hist(logic [1:0] act, logic [1:0] exp, string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02b expected %02b", req, act, exp);
    end
  endtask

  task automatic update(logic [31:0] pc, logic [1:0] h, logic taken);
    int idx;
    @(negedge clk);
    upd_valid = 1; upd_pc = pc; upd_hist = h; upd_taken = taken;
    @(posedge clk);
    #1 upd_valid = 0;
    idx = int'(pc[11:2]);
    if (taken) m_ctr[h][idx] = (m_ctr[h][idx] == 3) ? 3 : m_ctr[h][idx] + 1;
    else       m_ctr[h][idx] = (m_ctr[h][idx] == 0) ? 0 : m_ctr[h][idx] - 1;
    m_hist = {taken, m_hist[1]};
  endtask

  // steer the live history via the scratch entry of table 3
  task automatic set_hist(logic [1:0] h);
    update(pc_of(SCRATCH), 2'b11, h[0]);
    update(pc_of(SCRATCH), 2'b11, h[1]);
  endtask

  task automatic look(logic [31:0] pc, logic [1:0] h, string req);
    set_hist(h);
    @(negedge clk);
    lookup_pc = pc;
    #1;
    check_hist(pred_hist, h, req);
    check(pred_taken, m_ctr[h][int'(pc[11:2])] >= 2, req);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check_hist(pred_hist, 2'b00, "R1 history");
    for (int i = 0; i < 4; i++) begin
      lookup_pc = pc_of(i * 97);
      #1 check(pred_taken, 1'b0, "R1 initial direction");
    end
    // one taken update from 01 must flip to taken (proves 01, not 00)
    update(pc_of(3), 2'b00, 1'b1);
    look(pc_of(3), 2'b00, "R1 weak init");
  endtask

  task automatic t_shift();
    update(pc_of(SCRATCH), 2'b11, 1'b1);
    @(negedge clk) check_hist(pred_hist, m_hist, "R3 after taken");
    update(pc_of(SCRATCH), 2'b11, 1'b0);
    @(negedge clk) check_hist(pred_hist, 2'b01, "R3 newer nt, older t");
    update(pc_of(SCRATCH), 2'b11, 1'b1);
    @(negedge clk) check_hist(pred_hist, 2'b10, "R3 newer t, older nt");
  endtask

  task automatic t_idle();
    logic [1:0] h0;
    h0 = pred_hist;
    @(negedge clk);
    upd_valid = 0; upd_pc = pc_of(50); upd_hist = 2'b00; upd_taken = 1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check_hist(pred_hist, h0, "R9 history held");
    look(pc_of(50), 2'b00, "R9 counter untouched");
  endtask

  task automatic t_select();
    // train table k at index 10+k to taken, then probe each table
    for (int k = 0; k < 4; k++) begin
      update(pc_of(10 + k), 2'(k), 1'b1);
    end
    for (int k = 0; k < 4; k++) begin
      for (int h = 0; h < 4; h++) begin
        look(pc_of(10 + k), 2'(h), "R4 table select");
      end
    end
  endtask

  task automatic t_saturate_up();
    for (int i = 0; i < 4; i++) update(pc_of(20), 2'b10, 1'b1);
    look(pc_of(20), 2'b10, "R5 saturated high");
    update(pc_of(20), 2'b10, 1'b0);
    look(pc_of(20), 2'b10, "R5 one below max");
    update(pc_of(20), 2'b10, 1'b0);
    look(pc_of(20), 2'b10, "R5 back to weak nt");
    check(pred_taken, 1'b0, "R5 expected direction nt");
  endtask

  task automatic t_saturate_down();
    for (int i = 0; i < 3; i++) update(pc_of(30), 2'b01, 1'b0);
    look(pc_of(30), 2'b01, "R6 saturated low");
    update(pc_of(30), 2'b01, 1'b1);
    look(pc_of(30), 2'b01, "R6 up to 01");
    check(pred_taken, 1'b0, "R6 still nt");
    update(pc_of(30), 2'b01, 1'b1);
    look(pc_of(30), 2'b01, "R6 up to 10");
    check(pred_taken, 1'b1, "R6 now taken");
  endtask

  task automatic t_isolation();
    update(pc_of(5), 2'b10, 1'b1);
    for (int h = 0; h < 4; h++) look(pc_of(5), 2'(h), "R7 other tables");
    look(pc_of(4), 2'b10, "R7 neighbour index");
    look(pc_of(6), 2'b10, "R7 neighbour index");
  endtask

  task automatic t_alias();
    // same bits [11:2], different low and high bits
    update({20'hABCDE, 10'd40, 2'b11}, 2'b00, 1'b1);
    look(pc_of(40), 2'b00, "R8 alias hit");
    check(pred_taken, 1'b1, "R8 alias taken");
    look({20'h12345, 10'd40, 2'b01}, 2'b00, "R8 alias read");
    look(pc_of(41), 2'b00, "R8 next index");
  endtask

  initial begin
    for (int t = 0; t < 4; t++)
      for (int i = 0; i < 1024; i++) m_ctr[t][i] = 1;
    m_hist = 2'b00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_shift();
    t_idle();
    t_select();
    t_saturate_up();
    t_saturate_down();
    t_isolation();
    t_alias();
    // R2: direction follows a combinational PC change within the cycle
    look(pc_of(10), 2'b00, "R2 lookup");
    lookup_pc = pc_of(11);
    #1 check(pred_taken, 1'b0, "R2 same-cycle change");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule